// File: doc/BRIEF.md
# Bridge master-abort completion handler

This block sits in a bridge between a processor and an internal bus. It keeps a small buffer of outstanding processor requests and retires each one when the internal bus responds. Each response carries the tag of its request and a kind code. The code says whether the cycle completed normally or was master-aborted. An abort has one of two origins. The internal bus raises one when no target claims the cycle. A downstream PCI translation unit can also pass one back during a read completion.

Reads and writes end in different ways. A read always gets a one-cycle completion strobe toward the processor, and an aborted read also raises the abort flag in that same cycle. Writes are posted, so a write response only frees its buffer slot and returns nothing to the processor.

Only an abort from the internal bus itself is logged in the local status register and can raise the interrupt. An abort relayed from the translation unit is reported by that unit, so this block neither logs it nor interrupts for it. Software reads the status register, clears the status bit by writing one to it, and gates the interrupt with an enable bit.

Top module: `abort_retire`

## Requirements
- R1: After reset, reqReady is 1, cplDvalid and cplAbort are 0, csrRdData is 0 and irq is 0.
- R2: The buffer holds DEPTH requests. A request is accepted on a clock edge where reqValid and reqReady are both 1. reqReady is 0 while all DEPTH entries are outstanding. A request presented while the buffer is full is dropped, so a later response with its tag produces no completion.
- R3: A response for an outstanding read with rspKind 2'b00 (normal), or with the reserved code 2'b11, gives cplDvalid=1 and cplAbort=0 for one cycle. This happens in the cycle after the response, with cplTag equal to the response tag, and the entry is freed.
- R4: A response for an outstanding read with rspKind 2'b01 (internal-bus master-abort) drives cplDvalid and cplAbort both to 1 for exactly one cycle, the cycle after the response, and frees the entry.
- R5: A response for an outstanding read with rspKind 2'b10 (relayed PCI master-abort) drives cplDvalid=1 and cplAbort=1 for one cycle, frees the entry, and leaves the status bit (csrRdData bit 0) and irq unchanged.
- R6: A response of any kind for an outstanding write produces no completion (cplDvalid stays 0) and frees the entry.
- R7: An internal-bus master-abort (rspKind 2'b01) on an outstanding read or write sets status bit 0 at the next clock edge. A relayed PCI master-abort on a write leaves the status bit unchanged.
- R8: irq equals status bit 0 AND enable bit 1, and stays asserted until software clears the status bit. A register write (csrWr=1) loads the enable bit from csrWrData bit 1, and a 1 in csrWrData bit 0 clears the status bit. A 0 in csrWrData bit 0 leaves the status bit unchanged.
- R9: If an internal-bus abort sets the status bit in the same cycle as a write-one clear, the status bit ends up 1.
- R10: A response whose tag matches no outstanding entry is ignored: no completion, no status change, no change to the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present |
| reqWrite | input | 1 | Request is a posted write (1) or a read (0) |
| reqTag | input | TAG_W | Tag of the request |
| reqReady | output | 1 | Buffer has a free entry |
| rspValid | input | 1 | Internal-bus response present |
| rspTag | input | TAG_W | Tag of the request being answered |
| rspKind | input | 2 | 00 normal, 01 internal-bus abort, 10 relayed PCI abort, 11 treated as normal |
| cplDvalid | output | 1 | Read completion strobe to the processor |
| cplAbort | output | 1 | Completion is aborted (only together with cplDvalid) |
| cplTag | output | TAG_W | Tag of the completed read |
| csrWr | input | 1 | Status/control register write strobe |
| csrWrData | input | 2 | Bit 0: write 1 to clear status; bit 1: interrupt enable |
| csrRdData | output | 2 | Bit 0: internal-bus master-abort status; bit 1: enable |
| irq | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with its defaults, DEPTH=4 and TAG_W=4. A four-entry buffer can be filled with a short mix of reads and writes, which brings the full-buffer stall, the dropped request and the reuse of freed slots within reach. Four tag bits let every request in the run carry a distinct tag. A stale or dropped tag can then be told apart from a live one, and responses can retire entries out of order.

// File: rtl/abort_retire_pkg.sv
package abort_retire_pkg;

  typedef enum logic [1:0] {
    RSP_OK       = 2'b00,
    RSP_IBABORT  = 2'b01,
    RSP_PCIABORT = 2'b10,
    RSP_RSVD     = 2'b11
  } rspKind_e;

  typedef struct packed {
    logic retire;
    logic setStat;
    logic cplFire;
    logic cplAbt;
  } ctlStrb_t;

endpackage

// File: rtl/abort_retire_ctrl.sv
module abort_retire_ctrl
  import abort_retire_pkg::*;
(
  input  logic       rspValid,
  input  logic [1:0] rspKind,
  input  logic       bufHit,
  input  logic       hitWrite,
  output ctlStrb_t   strb
);

  rspKind_e kind;
  logic     hit;
  logic     isIb;
  logic     isPci;

  always_comb begin
    kind  = rspKind_e'(rspKind);
    hit   = rspValid && bufHit;
    isIb  = (kind == RSP_IBABORT);
    isPci = (kind == RSP_PCIABORT);

    // every matched response retires its entry
    strb.retire  = hit;
    // only reads complete toward the processor; writes are posted
    strb.cplFire = hit && !hitWrite;
    strb.cplAbt  = hit && !hitWrite && (isIb || isPci);
    // only an abort from the internal bus itself is logged here
    strb.setStat = hit && isIb;
  end

endmodule

// File: rtl/abort_retire_dpath.sv
module abort_retire_dpath
  import abort_retire_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [TAG_W-1:0] reqTag,
  output logic             reqReady,
  input  logic [TAG_W-1:0] rspTag,
  output logic             bufHit,
  output logic             hitWrite,
  input  ctlStrb_t         strb,
  input  logic             csrWr,
  input  logic [1:0]       csrWrData,
  output logic [1:0]       csrRdData,
  output logic             irq,
  output logic             cplDvalid,
  output logic             cplAbort,
  output logic [TAG_W-1:0] cplTag
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] validQ;
  logic [DEPTH-1:0] wrQ;
  logic [TAG_W-1:0] tagQ [DEPTH];

  logic [DEPTH-1:0] matchVec;
  logic [DEPTH-1:0] freeVec;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] allocIdx;
  logic             full;
  logic             alloc;

  logic             statQ;
  logic             enQ;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign matchVec[i] = validQ[i] && (tagQ[i] == rspTag);
    assign freeVec[i]  = !validQ[i];
  end

  always_comb begin
    hitIdx   = '0;
    allocIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
      if (freeVec[i])  allocIdx = IDX_W'(i);
    end
  end

  assign bufHit   = |matchVec;
  assign hitWrite = wrQ[hitIdx];
  assign full     = &validQ;
  assign reqReady = !full;
  assign alloc    = reqValid && !full;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      wrQ    <= '0;
      for (int i = 0; i < DEPTH; i++) tagQ[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.retire && (hitIdx == IDX_W'(i))) validQ[i] <= 1'b0;
        if (alloc && (allocIdx == IDX_W'(i))) begin
          validQ[i] <= 1'b1;
          wrQ[i]    <= reqWrite;
          tagQ[i]   <= reqTag;
        end
      end
    end
  end

  // status: set dominates the write-one clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= 1'b0;
      enQ   <= 1'b0;
    end else begin
      if (strb.setStat)                statQ <= 1'b1;
      else if (csrWr && csrWrData[0])  statQ <= 1'b0;
      if (csrWr) enQ <= csrWrData[1];
    end
  end

  assign csrRdData = {enQ, statQ};
  assign irq       = statQ && enQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cplDvalid <= 1'b0;
      cplAbort  <= 1'b0;
      cplTag    <= '0;
    end else begin
      cplDvalid <= strb.cplFire;
      cplAbort  <= strb.cplAbt;
      cplTag    <= rspTag;
    end
  end

  // R2: a full buffer with nothing retiring keeps its contents
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (full && !strb.retire) |=> $stable(validQ));

  // R3: a completion strobe follows a retirement decided by the control
  p_cpl_from_retire_r3: assert property (@(posedge clk) disable iff (!rstN)
    cplDvalid |-> $past(strb.retire));

  // R4: the abort flag never appears without the completion strobe
  p_abort_with_dvalid_r4: assert property (@(posedge clk) disable iff (!rstN)
    cplAbort |-> cplDvalid);

  // R7: status rises only when the control signalled an internal-bus abort
  p_stat_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statQ) |-> $past(strb.setStat));

  // R8: a write-one clear with no competing set drops the status bit
  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statQ && !strb.setStat && csrWr && csrWrData[0]) |=> !statQ);

  // R9: a set always lands, even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStat |=> statQ);

endmodule

// File: rtl/abort_retire.sv
module abort_retire
  import abort_retire_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [TAG_W-1:0] reqTag,
  output logic             reqReady,
  input  logic             rspValid,
  input  logic [TAG_W-1:0] rspTag,
  input  logic [1:0]       rspKind,
  output logic             cplDvalid,
  output logic             cplAbort,
  output logic [TAG_W-1:0] cplTag,
  input  logic             csrWr,
  input  logic [1:0]       csrWrData,
  output logic [1:0]       csrRdData,
  output logic             irq
);

  ctlStrb_t strb;
  logic     bufHit;
  logic     hitWrite;

  abort_retire_ctrl u_ctrl (
    .rspValid (rspValid),
    .rspKind  (rspKind),
    .bufHit   (bufHit),
    .hitWrite (hitWrite),
    .strb     (strb)
  );

  abort_retire_dpath #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqTag    (reqTag),
    .reqReady  (reqReady),
    .rspTag    (rspTag),
    .bufHit    (bufHit),
    .hitWrite  (hitWrite),
    .strb      (strb),
    .csrWr     (csrWr),
    .csrWrData (csrWrData),
    .csrRdData (csrRdData),
    .irq       (irq),
    .cplDvalid (cplDvalid),
    .cplAbort  (cplAbort),
    .cplTag    (cplTag)
  );

endmodule

// File: tb/abort_retire_tb.sv
module abort_retire_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 4;

  localparam logic [1:0] K_OK  = 2'b00;
  localparam logic [1:0] K_IB  = 2'b01;
  localparam logic [1:0] K_PCI = 2'b10;
  localparam logic [1:0] K_RSV = 2'b11;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqWrite = 1'b0;
  logic [TAG_W-1:0] reqTag = '0;
  logic             reqReady;
  logic             rspValid = 1'b0;
  logic [TAG_W-1:0] rspTag = '0;
  logic [1:0]       rspKind = '0;
  logic             cplDvalid;
  logic             cplAbort;
  logic [TAG_W-1:0] cplTag;
  logic             csrWr = 1'b0;
  logic [1:0]       csrWrData = '0;
  logic [1:0]       csrRdData;
  logic             irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abort_retire #(.DEPTH(4), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqTag(reqTag), .reqReady(reqReady),
    .rspValid(rspValid), .rspTag(rspTag), .rspKind(rspKind),
    .cplDvalid(cplDvalid), .cplAbort(cplAbort), .cplTag(cplTag),
    .csrWr(csrWr), .csrWrData(csrWrData), .csrRdData(csrRdData), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one request; returns at the negedge after the accepting edge
  task automatic issueReq(input logic [TAG_W-1:0] t, input logic w);
    reqValid = 1'b1; reqWrite = w; reqTag = t;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // one response with optional same-cycle register write; outputs of that edge visible on return
  task automatic sendRsp(input logic [TAG_W-1:0] t, input logic [1:0] k,
                         input logic wr, input logic [1:0] wd);
    rspValid = 1'b1; rspTag = t; rspKind = k;
    csrWr = wr; csrWrData = wd;
    @(negedge clk);
    rspValid = 1'b0; csrWr = 1'b0;
  endtask

  task automatic csrWrite(input logic [1:0] wd);
    csrWr = 1'b1; csrWrData = wd;
    @(negedge clk);
    csrWr = 1'b0;
  endtask

  task automatic tReset();
    check("R1 reqReady", int'(reqReady), 1);
    check("R1 cplDvalid", int'(cplDvalid), 0);
    check("R1 cplAbort", int'(cplAbort), 0);
    check("R1 csrRdData", int'(csrRdData), 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic tFill();
    csrWrite(2'b10);
    issueReq(4'd1, 1'b0);
    issueReq(4'd2, 1'b0);
    issueReq(4'd3, 1'b1);
    check("R2 ready with one free", int'(reqReady), 1);
    issueReq(4'd4, 1'b1);
    check("R2 ready low when full", int'(reqReady), 0);
    issueReq(4'd5, 1'b0);
    sendRsp(4'd5, K_OK, 1'b0, 2'b00);
    check("R2 dropped request no cpl", int'(cplDvalid), 0);
    check("R2 still full", int'(reqReady), 0);
  endtask

  task automatic tNormalRead();
    sendRsp(4'd1, K_OK, 1'b0, 2'b00);
    check("R3 dvalid", int'(cplDvalid), 1);
    check("R3 abort low", int'(cplAbort), 0);
    check("R3 tag", int'(cplTag), 1);
    check("R3 entry freed", int'(reqReady), 1);
    @(negedge clk);
    check("R3 one cycle", int'(cplDvalid), 0);
    sendRsp(4'd1, K_OK, 1'b0, 2'b00);
    check("R10 stale tag ignored", int'(cplDvalid), 0);
    check("R10 no status", int'(csrRdData[0]), 0);
  endtask

  task automatic tPciRead();
    sendRsp(4'd2, K_PCI, 1'b0, 2'b00);
    check("R5 dvalid", int'(cplDvalid), 1);
    check("R5 abort", int'(cplAbort), 1);
    check("R5 tag", int'(cplTag), 2);
    check("R5 status untouched", int'(csrRdData[0]), 0);
    check("R5 irq low", int'(irq), 0);
  endtask

  task automatic tWrites();
    sendRsp(4'd3, K_PCI, 1'b0, 2'b00);
    check("R6 pci write no cpl", int'(cplDvalid), 0);
    check("R7 pci write no status", int'(csrRdData[0]), 0);
    check("R7 pci write no irq", int'(irq), 0);
    sendRsp(4'd4, K_IB, 1'b0, 2'b00);
    check("R6 ib write no cpl", int'(cplDvalid), 0);
    check("R7 ib write sets status", int'(csrRdData[0]), 1);
    check("R8 irq asserted", int'(irq), 1);
    sendRsp(4'd4, K_IB, 1'b0, 2'b00);
    check("R6 write entry freed, retry ignored", int'(cplDvalid), 0);
  endtask

  task automatic tClear();
    csrWrite(2'b10);
    check("R8 write 0 keeps status", int'(csrRdData[0]), 1);
    check("R8 irq held", int'(irq), 1);
    csrWrite(2'b11);
    check("R8 w1c clears", int'(csrRdData[0]), 0);
    check("R8 irq drops", int'(irq), 0);
  endtask

  task automatic tIbRead();
    issueReq(4'd6, 1'b0);
    sendRsp(4'd6, K_IB, 1'b0, 2'b00);
    check("R4 dvalid", int'(cplDvalid), 1);
    check("R4 abort", int'(cplAbort), 1);
    check("R4 tag", int'(cplTag), 6);
    check("R7 ib read sets status", int'(csrRdData[0]), 1);
    @(negedge clk);
    check("R4 dvalid one cycle", int'(cplDvalid), 0);
    check("R4 abort one cycle", int'(cplAbort), 0);
  endtask

  task automatic tSetWins();
    issueReq(4'd7, 1'b0);
    sendRsp(4'd7, K_IB, 1'b1, 2'b11);
    check("R9 set beats clear", int'(csrRdData[0]), 1);
    csrWrite(2'b00);
    check("R8 enable off status kept", int'(csrRdData), 1);
    check("R8 irq gated", int'(irq), 0);
    csrWrite(2'b01);
    check("R8 cleared", int'(csrRdData), 0);
  endtask

  task automatic tReserved();
    check("R2 all retired ready", int'(reqReady), 1);
    issueReq(4'd8, 1'b0);
    sendRsp(4'd8, K_RSV, 1'b0, 2'b00);
    check("R3 reserved kind dvalid", int'(cplDvalid), 1);
    check("R3 reserved kind no abort", int'(cplAbort), 0);
    check("R3 reserved kind no status", int'(csrRdData[0]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFill();
    tNormalRead();
    tPciRead();
    tWrites();
    tClear();
    tIbRead();
    tSetWins();
    tReserved();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule